// File: doc/BRIEF.md
# Receive Byte Buffer with Windowed Readout and Count Acknowledge

This block is the receive store of a fast serial port. The deserializer delivers one byte per strobe on `rx_valid`/`rx_byte`. The block appends each byte to a circular store. The host never pops bytes one at a time. It reads 32-bit words through a window that starts at the oldest unread byte, copies as many bytes as it wants, and then writes the number it consumed to `ack_count` with `ack_valid`. That write advances the read position and frees the space.

A 32-bit status word carries the current fill level. The level is split into a low byte at the top of the word and two high bits near the bottom. The same word carries three flags: overrun, data-available and character-timeout. Data-available rises when the fill reaches a threshold chosen by a 3-bit level code. Character-timeout rises when unread data has seen no line or host activity for a programmed number of time units. Each unit lasts four times the baud divisor in clock cycles.

Top module: `rx_window_buffer`

## Requirements
- R1: After synchronous reset, the status word is all zero and both request outputs are low.
- R2: Each `rx_valid` cycle accepted while the fill is below 1023 stores `rx_byte` after the newest byte and raises the fill by one.
- R3: `status[31:24]` holds fill bits 7..0 and `status[7:6]` holds fill bits 9..8. `status[0]` is overrun, `status[1]` is data-available and `status[2]` is character-timeout. All other bits read zero.
- R4: For window word w (0..254), `win_data[8b+7:8b]` is the byte stored at read position + 4w + b.
- R5: Window word 255 always reads as zero.
- R6: An `ack_valid` cycle with count N, where N is no larger than the fill, lowers the fill by N and moves window byte 0 forward by N bytes.
- R7: An acknowledge count larger than the fill is clamped to the fill, so the fill ends at zero.
- R8: The store holds at most 1023 bytes. A byte that arrives while the store is full is discarded and sets overrun. Any `ack_valid` cycle clears overrun, except when a byte is discarded in that same cycle, in which case overrun stays set.
- R9: With level code n (0..7), data-available is high exactly while the fill is at least 2^(n+2).
- R10: With a nonzero timeout T and divisor D, character-timeout rises T*4*D cycles after the last `rx_valid` or `ack_valid` cycle if the fill is nonzero. A new byte or an acknowledge drops it. A timeout of zero disables it.
- R11: Storage positions wrap modulo 1024. Window reads that cross the end of the store return the bytes in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| ack_valid | input | 1 | Host acknowledge strobe |
| ack_count | input | 11 | Number of bytes consumed by the host |
| win_word | input | 8 | Word index into the read window |
| win_data | output | 32 | Window word, little-endian byte order |
| cfg_rx_level | input | 3 | Data-available level code |
| cfg_timeout | input | TMO_W | Idle timeout in units, 0 = off |
| cfg_baud_div | input | DIV_W | Baud divisor, sets the unit length |
| status | output | 32 | Fill level and flags |
| irq_data_avail | output | 1 | Data-available request |
| irq_char_timeout | output | 1 | Character-timeout indication |

## Verification
A wrong read pointer shows up at once as window word 0 holding the wrong byte. Because every byte the bench sends is its own arrival index, any slip in pointer or wrap arithmetic changes the value seen in the very next window read. A wrong fill counter appears in both status fields the cycle after the push or acknowledge that caused it, and it also skews data-available against its threshold. Faults in the idle counter show up as character-timeout rising one unit early or late, and the bench samples on each side of the expected edge to catch that.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    localparam int FILL_W = 10;
    localparam int DEPTH  = 1 << FILL_W;
    localparam int LVL_W  = 3;

    typedef struct packed {
        logic [7:0]  cnt_lo;
        logic [15:0] rsvd_hi;
        logic [1:0]  cnt_hi;
        logic [2:0]  rsvd_lo;
        logic        cti;
        logic        rda;
        logic        ovr;
    } status_t;

    function automatic logic [FILL_W:0] trig_threshold(input logic [LVL_W-1:0] lvl);
        return (FILL_W+1)'(1) << ({1'b0, lvl} + 4'd2);
    endfunction

    function automatic status_t pack_status(input logic [FILL_W-1:0] fill,
                                            input logic ovr, input logic rda,
                                            input logic cti);
        status_t s;
        s         = '0;
        s.cnt_lo  = fill[7:0];
        s.cnt_hi  = fill[9:8];
        s.ovr     = ovr;
        s.rda     = rda;
        s.cti     = cti;
        return s;
    endfunction
endpackage

// File: rtl/rxw_store.sv
module rxw_store #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic [7:0]    push_byte,
    input  logic          ack_req,
    input  logic [AW:0]   ack_cnt,
    input  logic [AW-3:0] win_word,
    output logic [AW-1:0] fill,
    output logic          overrun,
    output logic [31:0]   rd_word
);
    localparam logic [AW-1:0] FULL_LVL = AW'(DEPTH - 1);
    localparam logic [AW-3:0] LAST_WORD = '1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q, fill_q, ack_eff;
    logic          ovr_q, full, accept;

    assign full   = (fill_q == FULL_LVL);
    assign accept = push_req && !full;

    always_comb begin
        ack_eff = '0;
        if (ack_req)
            ack_eff = (ack_cnt > {1'b0, fill_q}) ? fill_q : ack_cnt[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (accept) mem[wr_q] <= push_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= '0;
            rd_q   <= '0;
            fill_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            wr_q   <= wr_q + {{(AW-1){1'b0}}, accept};
            rd_q   <= rd_q + ack_eff;
            fill_q <= fill_q + {{(AW-1){1'b0}}, accept} - ack_eff;
            if (push_req && full) ovr_q <= 1'b1;
            else if (ack_req)     ovr_q <= 1'b0;
        end
    end

    for (genvar b = 0; b < 4; b++) begin : g_lane
        logic [AW-1:0] idx;
        assign idx = rd_q + {win_word, 2'b00} + AW'(b);
        assign rd_word[8*b +: 8] = (win_word == LAST_WORD) ? 8'h00 : mem[idx];
    end

    assign fill    = fill_q;
    assign overrun = ovr_q;
endmodule

// File: rtl/rxw_trigger.sv
module rxw_trigger
    import rxw_pkg::*;
#(
    parameter int TMO_W = 16,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FILL_W-1:0] fill,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [TMO_W-1:0]  tmo,
    input  logic [DIV_W-1:0]  div,
    input  logic              activity,
    output logic              rda,
    output logic              cti
);
    logic [DIV_W+1:0] pre_q, pre_last;
    logic [TMO_W-1:0] unit_q;

    assign pre_last = {div, 2'b00} - (DIV_W+2)'(1);

    always_ff @(posedge clk) begin
        if (rst || activity) begin
            pre_q  <= '0;
            unit_q <= '0;
        end else if (pre_q == pre_last) begin
            pre_q <= '0;
            if (unit_q != '1) unit_q <= unit_q + TMO_W'(1);
        end else begin
            pre_q <= pre_q + (DIV_W+2)'(1);
        end
    end

    assign rda = ({1'b0, fill} >= trig_threshold(lvl));
    assign cti = (fill != '0) && (tmo != '0) && (unit_q >= tmo);
endmodule

// File: rtl/rx_window_buffer.sv
module rx_window_buffer
    import rxw_pkg::*;
#(
    parameter int TMO_W = 16,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              ack_valid,
    input  logic [FILL_W:0]   ack_count,
    input  logic [FILL_W-3:0] win_word,
    output logic [31:0]       win_data,
    input  logic [LVL_W-1:0]  cfg_rx_level,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic [DIV_W-1:0]  cfg_baud_div,
    output logic [31:0]       status,
    output logic              irq_data_avail,
    output logic              irq_char_timeout
);
    logic [FILL_W-1:0] fill;
    logic              overrun;

    rxw_store #(.DEPTH(DEPTH), .AW(FILL_W)) i_store (
        .clk(clk), .rst(rst),
        .push_req(rx_valid), .push_byte(rx_byte),
        .ack_req(ack_valid), .ack_cnt(ack_count),
        .win_word(win_word),
        .fill(fill), .overrun(overrun), .rd_word(win_data)
    );

    rxw_trigger #(.TMO_W(TMO_W), .DIV_W(DIV_W)) i_trig (
        .clk(clk), .rst(rst), .fill(fill), .lvl(cfg_rx_level),
        .tmo(cfg_timeout), .div(cfg_baud_div),
        .activity(rx_valid || ack_valid),
        .rda(irq_data_avail), .cti(irq_char_timeout)
    );

    assign status = pack_status(fill, overrun, irq_data_avail, irq_char_timeout);
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
    parameter int FW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_valid,
    input logic          ack_valid,
    input logic [FW:0]   ack_count,
    input logic [FW-1:0] fill,
    input logic          overrun,
    input logic          rda,
    input logic          cti
);
    localparam logic [FW-1:0] FULL_LVL = '1;

    p_push_count_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && fill != FULL_LVL && !ack_valid) |=> (fill == $past(fill) + 1'b1));

    p_clamp_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_count >= {1'b0, fill} && !rx_valid) |=> (fill == '0));

    p_drop_full_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && fill == FULL_LVL && !ack_valid) |=> (overrun && fill == FULL_LVL));

    p_ovr_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !rx_valid) |=> !overrun);

    p_rda_data_r9: assert property (@(posedge clk) disable iff (rst)
        rda |-> (fill != '0));

    p_cti_data_r10: assert property (@(posedge clk) disable iff (rst)
        cti |-> (fill != '0));

    p_cti_drop_r10: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !cti);
endmodule

bind rx_window_buffer rxw_checker #(.FW(rxw_pkg::FILL_W)) i_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .ack_valid(ack_valid),
    .ack_count(ack_count), .fill(fill), .overrun(overrun),
    .rda(irq_data_avail), .cti(irq_char_timeout)
);

// File: tb/test_rx_window_buffer.sv
`timescale 1ns/1ps
module test_rx_window_buffer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        ack_valid = 1'b0;
    logic [10:0] ack_count = '0;
    logic [7:0]  win_word = '0;
    logic [31:0] win_data;
    logic [2:0]  cfg_rx_level = '0;
    logic [15:0] cfg_timeout = '0;
    logic [15:0] cfg_baud_div = 16'd1;
    logic [31:0] status;
    logic        irq_data_avail, irq_char_timeout;

    int n_chk = 0, n_fail = 0;
    int mfill = 0, wr_seq = 0, rd_seq = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_window_buffer i_rx_window_buffer (.*);

    // rows: push count [31:21], ack count [20:10], expected fill [9:0]
    localparam logic [31:0] VEC [7] = '{
        {11'd10,  11'd0,    10'd10},
        {11'd0,   11'd3,    10'd7},
        {11'd20,  11'd27,   10'd0},
        {11'd300, 11'd100,  10'd200},
        {11'd500, 11'd1000, 10'd0},
        {11'd900, 11'd0,    10'd900},
        {11'd0,   11'd900,  10'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] st_fill();
        return {status[7:6], status[31:24]};
    endfunction

    function automatic logic [31:0] exp_word(input int w);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = 8'(rd_seq + 4*w + b);
        return r;
    endfunction

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = 8'(wr_seq);
            if (mfill < 1023) begin
                mfill++;
                wr_seq++;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic ack(input int n);
        int e;
        e = (n > mfill) ? mfill : n;
        @(negedge clk);
        ack_valid = 1'b1;
        ack_count = 11'(n);
        @(negedge clk);
        ack_valid = 1'b0;
        mfill  -= e;
        rd_seq += e;
    endtask

    task automatic read_word(input int w, output logic [31:0] d);
        win_word = 8'(w);
        #1 d = win_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 status", status, 32'h0);
        chk("R1 irqs", {30'h0, irq_data_avail, irq_char_timeout}, 32'h0);

        for (int r = 0; r < 7; r++) begin
            push(int'(VEC[r][31:21]));
            if (VEC[r][20:10] != 0) ack(int'(VEC[r][20:10]));
            chk("R2/R6/R7 fill", 32'(st_fill()), 32'(VEC[r][9:0]));
            chk("R3 reserved bits", status & 32'h00FF_FF38, 32'h0);
            if (mfill >= 4) begin
                read_word(0, d);
                chk("R4/R11 word 0", d, exp_word(0));
                read_word(mfill/4 - 1, d);
                chk("R4/R11 last full word", d, exp_word(mfill/4 - 1));
            end
            read_word(255, d);
            chk("R5 final word", d, 32'h0);
        end

        // R9 trigger level
        push(3);
        chk("R9 below 4", {31'h0, irq_data_avail}, 32'h0);
        push(1);
        chk("R9 at 4", {31'h0, irq_data_avail}, 32'h1);
        chk("R3 rda bit", {31'h0, status[1]}, 32'h1);
        cfg_rx_level = 3'd1;
        #1 chk("R9 level 1 needs 8", {31'h0, irq_data_avail}, 32'h0);
        cfg_rx_level = 3'd0;
        ack(4);

        // R10 character timeout: T=5, D=1 -> 20 cycles
        cfg_timeout = 16'd5;
        push(1);
        repeat (19) @(negedge clk);
        chk("R10 before expiry", {31'h0, irq_char_timeout}, 32'h0);
        @(negedge clk);
        chk("R10 at expiry", {31'h0, irq_char_timeout}, 32'h1);
        chk("R3 cti bit", {31'h0, status[2]}, 32'h1);
        push(1);
        chk("R10 cleared by byte", {31'h0, irq_char_timeout}, 32'h0);
        cfg_timeout = 16'd0;
        repeat (40) @(negedge clk);
        chk("R10 disabled", {31'h0, irq_char_timeout}, 32'h0);
        ack(2);

        // R8 overflow
        push(1030);
        chk("R8 full fill", 32'(st_fill()), 32'd1023);
        chk("R8 overrun set", {31'h0, status[0]}, 32'h1);
        read_word(0, d);
        chk("R8 kept bytes", d, exp_word(0));
        read_word(254, d);
        chk("R8 R11 tail bytes", d, exp_word(254));
        ack(0);
        chk("R8 overrun cleared", {31'h0, status[0]}, 32'h0);
        chk("R8 fill unchanged", 32'(st_fill()), 32'd1023);
        ack(2000);
        chk("R7 clamp to zero", 32'(st_fill()), 32'd0);

        // R1 reset mid-run
        push(5);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 status after reset", status, 32'h0);
        chk("R1 irqs after reset", {30'h0, irq_data_avail, irq_char_timeout}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule